// File: doc/BRIEF.md
# Floating-Point NaN Classifier and Quieter

This block takes one floating-point operand per transfer and reports whether it is a quiet NaN or a signaling NaN. It also returns the operand with any signaling NaN turned into a quiet one, and the default NaN pattern that the current mode would generate. The operand width is fixed by a parameter: 16, 32 or 64 bits, for half, single or double precision. Exponent and fraction widths follow from that parameter.

Four mode inputs travel with each operand:
- `inv_sig` selects the inverted convention, in which a set top fraction bit marks a signaling NaN.
- `all_quiet` treats every NaN as quiet.
- `dnan_sel` chooses the default-NaN style.
- `alt_silence` chooses how the inverted convention silences a NaN.

Operands enter on a valid/ready stream and leave on a second valid/ready stream through one register stage.
- An operand is accepted on a rising clock edge when `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or `out_ready` is high.
- While `out_valid` is high and `out_ready` is low, every output holds its value.

The block is used to classify and sanitise NaN operands ahead of arithmetic that has to follow a particular NaN convention.

Top module: `fpnan_unit`

## Requirements
- R1: The block accepts an operand on a rising edge when `in_valid && in_ready`, and its results appear with `out_valid` on the next edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, `out_valid` and all result outputs stay unchanged.
- R2: The normal convention applies when `inv_sig=0` and `all_quiet=0`. In this convention a value is quiet when its exponent field is all ones and its top fraction bit is set (bit 9, 22 or 51 for 16, 32 or 64 bits). It is signaling when the exponent is all ones, the top fraction bit is clear and some lower fraction bit is set. The sign bit is ignored.
- R3: When `inv_sig=1` and `all_quiet=0`, the quiet and signaling tests of R2 swap roles.
- R4: When `all_quiet=1`, `out_signaling` is 0 and `out_quiet` is 1 for any NaN, in either convention.
- R5: In the normal convention, a signaling NaN is output with its top fraction bit set and its sign and other payload bits kept.
- R6: In the inverted convention, a signaling NaN is replaced by the default NaN when `alt_silence=0`. When `alt_silence=1`, its top fraction bit is cleared and the bit below it is set, with all other bits kept.
- R7: With `inv_sig=0`, `out_default` has the exponent field all ones and, by `dnan_sel`:
  - 0: positive sign, only the top fraction bit set (single 0x7FC00000).
  - 1: as 0 but with the sign set (0xFFC00000).
  - 2: positive sign, all fraction bits set (0x7FFFFFFF).
  - 3: positive sign, only the second fraction bit from the top set (0x7FA00000).
- R8: With `inv_sig=1`, `out_default` is positive with all exponent bits set, the top fraction bit clear and all other fraction bits set (single 0x7FBFFFFF, half 0x7DFF), whatever `dnan_sel` is.
- R9: Zeros, infinities, normal and subnormal numbers, and NaNs that are not signaling under the current mode give both flags low except as R2 to R4 say. They pass to `out_data` unchanged.
- R10: While `rst_n` is low, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand and mode bits are offered |
| in_ready | output | 1 | Block can take an operand this cycle |
| in_data | input | FMT_W | Operand |
| inv_sig | input | 1 | Inverted signaling-bit convention |
| all_quiet | input | 1 | Treat every NaN as quiet |
| dnan_sel | input | 2 | Default-NaN style, see R7 |
| alt_silence | input | 1 | Alternative silencing in inverted convention |
| out_valid | output | 1 | Results are valid |
| out_ready | input | 1 | Consumer takes results this cycle |
| out_quiet | output | 1 | Operand was a quiet NaN |
| out_signaling | output | 1 | Operand was a signaling NaN |
| out_data | output | FMT_W | Operand with any signaling NaN silenced |
| out_default | output | FMT_W | Default NaN for the operand's mode |

## Verification
The hardest case to reach is one particular combination. The operand must be a NaN at a payload boundary: a payload of exactly one, a full payload below the top bit, or an empty payload with only the top bit set. At the same time, it must meet each of the 32 mode combinations while the output is stalled. Under that combination the swapped tests and the alternative silencer would produce a wrong value that could be held and then overwritten unseen. The stimulus steps through a fixed list of such boundary operands for every mode, in all three formats at once. It also throttles `out_ready` and `in_valid` with two coprime periods, so that stalls fall on every kind of operand.

// File: rtl/fpnan_pkg.sv
package fpnan_pkg;

  typedef struct packed {
    logic       inv_sig;
    logic       all_quiet;
    logic [1:0] dnan_sel;
    logic       alt_silence;
  } nan_mode_t;

  function automatic int exp_width(input int fmt_w);
    if (fmt_w == 16) return 5;
    else if (fmt_w == 64) return 11;
    else return 8;
  endfunction

endpackage

// File: rtl/fpnan_classify.sv
module fpnan_classify
  import fpnan_pkg::*;
#(
  parameter int FMT_W = 32
) (
  input  logic [FMT_W-1:0] x,
  input  nan_mode_t        mode,
  output logic             is_quiet,
  output logic             is_signaling
);
  localparam int EXP_W  = exp_width(FMT_W);
  localparam int FRAC_W = FMT_W - 1 - EXP_W;

  logic exp_ones, top_bit, low_nz, any_nan, std_q, std_s;

  assign exp_ones = &x[FMT_W-2 -: EXP_W];
  assign top_bit  = x[FRAC_W-1];
  assign low_nz   = |x[FRAC_W-2:0];
  assign any_nan  = exp_ones && (top_bit || low_nz);
  assign std_q    = exp_ones && top_bit;
  assign std_s    = exp_ones && !top_bit && low_nz;

  always_comb begin
    if (mode.all_quiet) begin
      is_quiet     = any_nan;
      is_signaling = 1'b0;
    end else if (mode.inv_sig) begin
      is_quiet     = std_s;
      is_signaling = std_q;
    end else begin
      is_quiet     = std_q;
      is_signaling = std_s;
    end
  end
endmodule

// File: rtl/fpnan_default.sv
module fpnan_default
  import fpnan_pkg::*;
#(
  parameter int FMT_W = 32
) (
  input  nan_mode_t        mode,
  output logic [FMT_W-1:0] dflt
);
  localparam int EXP_W  = exp_width(FMT_W);
  localparam int FRAC_W = FMT_W - 1 - EXP_W;
  localparam logic [FMT_W-1:0] ONE       = {{(FMT_W-1){1'b0}}, 1'b1};
  localparam logic [FMT_W-1:0] EXP_FIELD = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [FMT_W-1:0] FRAC_ALL  = {{(EXP_W+1){1'b0}}, {FRAC_W{1'b1}}};
  localparam logic [FMT_W-1:0] SIGN_BIT  = {1'b1, {(FMT_W-1){1'b0}}};
  localparam logic [FMT_W-1:0] TOP_FRAC  = ONE << (FRAC_W-1);
  localparam logic [FMT_W-1:0] NEXT_FRAC = ONE << (FRAC_W-2);

  always_comb begin
    if (mode.inv_sig) begin
      dflt = EXP_FIELD | (FRAC_ALL & ~TOP_FRAC);
    end else begin
      case (mode.dnan_sel)
        2'd0:    dflt = EXP_FIELD | TOP_FRAC;
        2'd1:    dflt = SIGN_BIT | EXP_FIELD | TOP_FRAC;
        2'd2:    dflt = EXP_FIELD | FRAC_ALL;
        default: dflt = EXP_FIELD | NEXT_FRAC;
      endcase
    end
  end
endmodule

// File: rtl/fpnan_quieter.sv
module fpnan_quieter
  import fpnan_pkg::*;
#(
  parameter int FMT_W = 32
) (
  input  logic [FMT_W-1:0] x,
  input  logic             is_signaling,
  input  nan_mode_t        mode,
  input  logic [FMT_W-1:0] dflt,
  output logic [FMT_W-1:0] y
);
  localparam int EXP_W  = exp_width(FMT_W);
  localparam int FRAC_W = FMT_W - 1 - EXP_W;
  localparam logic [FMT_W-1:0] ONE       = {{(FMT_W-1){1'b0}}, 1'b1};
  localparam logic [FMT_W-1:0] TOP_FRAC  = ONE << (FRAC_W-1);
  localparam logic [FMT_W-1:0] NEXT_FRAC = ONE << (FRAC_W-2);

  always_comb begin
    if (!is_signaling)
      y = x;
    else if (!mode.inv_sig)
      y = x | TOP_FRAC;
    else if (mode.alt_silence)
      y = (x & ~TOP_FRAC) | NEXT_FRAC;
    else
      y = dflt;
  end
endmodule

// File: rtl/fpnan_unit.sv
module fpnan_unit
  import fpnan_pkg::*;
#(
  parameter int FMT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [FMT_W-1:0] in_data,
  input  logic             inv_sig,
  input  logic             all_quiet,
  input  logic [1:0]       dnan_sel,
  input  logic             alt_silence,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_quiet,
  output logic             out_signaling,
  output logic [FMT_W-1:0] out_data,
  output logic [FMT_W-1:0] out_default
);
  localparam int EXP_W  = exp_width(FMT_W);
  localparam int FRAC_W = FMT_W - 1 - EXP_W;
  localparam logic [FMT_W-1:0] EXP_FIELD = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  nan_mode_t        mode;
  logic             c_quiet, c_sig, accept;
  logic [FMT_W-1:0] c_dflt, c_data;

  assign mode     = '{inv_sig: inv_sig, all_quiet: all_quiet, dnan_sel: dnan_sel,
                      alt_silence: alt_silence};
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  fpnan_classify #(.FMT_W(FMT_W)) u_class (
    .x(in_data), .mode(mode), .is_quiet(c_quiet), .is_signaling(c_sig));

  fpnan_default #(.FMT_W(FMT_W)) u_dflt (.mode(mode), .dflt(c_dflt));

  fpnan_quieter #(.FMT_W(FMT_W)) u_quiet (
    .x(in_data), .is_signaling(c_sig), .mode(mode), .dflt(c_dflt), .y(c_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      out_quiet     <= c_quiet;
      out_signaling <= c_sig;
      out_data      <= c_data;
      out_default   <= c_dflt;
    end
  end

  a_r10_reset_idle: assert property (@(posedge clk) !rst_n |=> !out_valid);

  a_r1_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_default)
                                   && $stable(out_quiet) && $stable(out_signaling)));

  a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_quiet && out_signaling));

  a_r4_no_signaling: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && all_quiet) |=> !out_signaling);

  a_r5_top_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !inv_sig && !all_quiet && c_sig) |=> out_data[FRAC_W-1]);

  a_r8_inverted_default: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && inv_sig) |=> (((out_default & EXP_FIELD) == EXP_FIELD)
                             && !out_default[FRAC_W-1] && !out_default[FMT_W-1]));
endmodule

// File: tb/fpnan_unit_test.sv
module fpnan_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NPAT  = 13;
  localparam int TOTAL = NPAT * 32;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic inv_sig = 1'b0, all_quiet = 1'b0, alt_silence = 1'b0;
  logic [1:0] dnan_sel = 2'd0;
  logic [15:0] d16 = '0;
  logic [31:0] d32 = '0;
  logic [63:0] d64 = '0;

  logic rdy16, rdy32, rdy64, ov16, ov32, ov64;
  logic q16, q32, q64, s16, s32, s64;
  logic [15:0] y16, f16;
  logic [31:0] y32, f32;
  logic [63:0] y64, f64;

  fpnan_unit #(.FMT_W(32)) uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy32),
    .in_data(d32), .inv_sig(inv_sig), .all_quiet(all_quiet), .dnan_sel(dnan_sel),
    .alt_silence(alt_silence), .out_valid(ov32), .out_ready(out_ready), .out_quiet(q32),
    .out_signaling(s32), .out_data(y32), .out_default(f32));
  fpnan_unit #(.FMT_W(16)) uut_h (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy16),
    .in_data(d16), .inv_sig(inv_sig), .all_quiet(all_quiet), .dnan_sel(dnan_sel),
    .alt_silence(alt_silence), .out_valid(ov16), .out_ready(out_ready), .out_quiet(q16),
    .out_signaling(s16), .out_data(y16), .out_default(f16));
  fpnan_unit #(.FMT_W(64)) uut_d (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy64),
    .in_data(d64), .inv_sig(inv_sig), .all_quiet(all_quiet), .dnan_sel(dnan_sel),
    .alt_silence(alt_silence), .out_valid(ov64), .out_ready(out_ready), .out_quiet(q64),
    .out_signaling(s64), .out_data(y64), .out_default(f64));

  int checks = 0, fails = 0;

  function automatic int ew(input int w);
    return (w == 16) ? 5 : (w == 64) ? 11 : 8;
  endfunction

  function automatic logic [63:0] pat(input int w, input int k);
    int e = ew(w);
    int f = w - 1 - e;
    logic [63:0] eo  = ((64'd1 << e) - 1) << f;
    logic [63:0] sg  = 64'd1 << (w - 1);
    logic [63:0] top = 64'd1 << (f - 1);
    logic [63:0] fm  = (64'd1 << f) - 1;
    case (k)
      0: return 64'd0;
      1: return sg;
      2: return eo;
      3: return sg | eo;
      4: return ((64'd1 << (e - 1)) - 1) << f;
      5: return eo | 64'd1;
      6: return eo | (top - 1);
      7: return eo | top;
      8: return eo | fm;
      9: return sg | eo | (top >> 1);
      10: return (eo - (64'd1 << f)) | fm;
      11: return 64'd1;
      default: return sg | eo | top | 64'd5;
    endcase
  endfunction

  function automatic void model(input int w, input logic [63:0] x, input logic inv, aq,
      input logic [1:0] sel, input logic alt, output logic q, s, nan,
      output logic [63:0] y, dfl);
    int e = ew(w);
    int f = w - 1 - e;
    logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
    logic [63:0] xm   = x & mask;
    logic [63:0] absv = xm & (mask >> 1);
    logic [63:0] eo   = ((64'd1 << e) - 1) << f;
    logic [63:0] top  = 64'd1 << (f - 1);
    logic [63:0] fm   = (64'd1 << f) - 1;
    logic sq, ss;
    nan = absv > eo;
    sq  = absv >= (eo | top);
    ss  = nan && !sq;
    if (aq) begin q = nan; s = 1'b0; end
    else if (inv) begin q = ss; s = sq; end
    else begin q = sq; s = ss; end
    if (inv) dfl = eo | (fm & ~top);
    else case (sel)
      2'd0: dfl = eo | top;
      2'd1: dfl = (64'd1 << (w - 1)) | eo | top;
      2'd2: dfl = eo | fm;
      default: dfl = eo | (top >> 1);
    endcase
    if (!s) y = xm;
    else if (!inv) y = xm | top;
    else if (alt) y = (xm & ~top) | (top >> 1);
    else y = dfl;
  endfunction

  // reference pipeline state
  logic        m_valid;
  logic        m_inv, m_aq;
  logic        m_q[3], m_s[3], m_nan[3];
  logic [63:0] m_y[3], m_d[3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_valid <= 1'b0;
    else if (!m_valid || out_ready) begin
      m_valid <= in_valid;
      if (in_valid) begin
        m_inv <= inv_sig;
        m_aq  <= all_quiet;
        for (int i = 0; i < 3; i++) begin
          logic q, s, n;
          logic [63:0] y, d;
          model(i == 0 ? 16 : i == 1 ? 32 : 64,
                i == 0 ? {48'd0, d16} : i == 1 ? {32'd0, d32} : d64,
                inv_sig, all_quiet, dnan_sel, alt_silence, q, s, n, y, d);
          m_q[i] <= q; m_s[i] <= s; m_nan[i] <= n; m_y[i] <= y; m_d[i] <= d;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    for (int i = 0; i < 3; i++) begin
      logic ov, rd, q, s;
      logic [63:0] y, d;
      string ft, dt;
      case (i)
        0: begin ov = ov16; rd = rdy16; q = q16; s = s16; y = {48'd0, y16}; d = {48'd0, f16}; end
        1: begin ov = ov32; rd = rdy32; q = q32; s = s32; y = {32'd0, y32}; d = {32'd0, f32}; end
        default: begin ov = ov64; rd = rdy64; q = q64; s = s64; y = y64; d = f64; end
      endcase
      chk("R1", "out_valid", {63'd0, ov}, {63'd0, m_valid});
      chk("R1", "in_ready", {63'd0, rd}, {63'd0, (!m_valid || out_ready)});
      if (m_valid) begin
        ft = m_aq ? "R4" : m_inv ? "R3" : "R2";
        dt = !m_s[i] ? "R9" : m_inv ? "R6" : "R5";
        chk(ft, "quiet flag", {63'd0, q}, {63'd0, m_q[i]});
        chk(ft, "signaling flag", {63'd0, s}, {63'd0, m_s[i]});
        chk(dt, "silenced data", y, m_y[i]);
        chk(m_inv ? "R8" : "R7", "default NaN", d, m_d[i]);
      end
    end
  endtask

  task automatic run();
    int idx = 0;
    int cyc = 0;
    logic acc = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", "out_valid in reset", {61'd0, ov16, ov32, ov64}, 64'd0);
    rst_n = 1'b1;
    while (idx < TOTAL) begin
      @(negedge clk);
      compare();
      if (acc) idx++;
      cyc++;
      out_ready = ((cyc % 5) != 3) && ((cyc % 7) != 0);
      if (idx < TOTAL) begin
        int k = idx % NPAT;
        int md = idx / NPAT;
        in_valid    = (cyc % 6) != 4;
        inv_sig     = md[4];
        all_quiet   = md[3];
        dnan_sel    = md[2:1];
        alt_silence = md[0];
        d16 = pat(16, k) & 64'hFFFF;
        d32 = pat(32, k) & 64'hFFFF_FFFF;
        d64 = pat(64, k);
      end else begin
        in_valid = 1'b0;
      end
      acc = in_valid && (!m_valid || out_ready);
    end
    out_ready = 1'b1;
    repeat (4) begin
      @(negedge clk);
      compare();
    end
  endtask

  initial begin
    fork
      run();
      begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule